// File: doc/BRIEF.md
# Iterative multiply execute sequencer

This block is the timing and control part of a three-stage integer back end with an execute stage, a memory stage and a write stage. Issue logic offers one operation at a time as a 4-bit class code on a valid/ready handshake. The sequencer keeps the operation in execute for as many iterations as its class needs, then moves it through memory and write one cycle each. While execute still has iterations left, it asserts a stall toward issue.

Each class has its own result point. Simple ALU work is ready as soon as execute is done. Some multiplies are ready only once the memory stage is done. Flag-setting multiplies produce their value one iteration before the flags, and they keep iterating after the value is out. The sequencer raises a value-ready strobe and a flags-ready strobe in the cycle a result becomes usable. The arithmetic itself lives elsewhere.

Top module: `mulExecSeq`

## Requirements
- R1: While reset is low and in the first cycle after it, `exBusy`, `memBusy`, `wbBusy`, `stall`, `valueReady` and `flagsReady` are 0 and `opReady` is 1.
- R2: An operation is accepted at a rising edge where `opValid` and `opReady` are both 1, and `opReady` is always the inverse of `stall`.
- R3: An accepted operation holds execute (`exBusy` = 1) for N cycles starting right after the accepting edge. N is 1 for codes 0, 1 and 3, 2 for codes 2, 4 and 5, 3 for code 7, 4 for code 6 and 5 for code 8.
- R4: Codes 0 (plain ALU) and 1 (shift by constant) pulse `valueReady` in the cycle after their single execute cycle.
- R5: Code 2 (shift by register) pulses `valueReady` in the cycle after its second execute cycle.
- R6: Code 3 (halfword multiply) pulses `valueReady` in the cycle after its memory cycle, which is the second cycle after execute.
- R7: Code 4 (halfword multiply-accumulate) pulses `valueReady` in the cycle after its second execute cycle.
- R8: Codes 5 (32-bit multiply) and 7 (long multiply) pulse `valueReady` in the cycle after their memory cycle.
- R9: Code 6 pulses `valueReady` during its 4th execute iteration, and code 8 does so during its 5th. Both then pulse `flagsReady` in the cycle after execute, while they occupy memory. No other code raises `flagsReady`.
- R10: Codes 9 to 15 behave exactly like code 0.
- R11: After its last execute cycle an operation occupies memory (`memBusy`) for one cycle and then write (`wbBusy`) for one cycle.
- R12: `stall` is 1 in every execute cycle except the last one. During those cycles `opValid` and `opClass` are ignored, and the operation in execute keeps its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Issue offers an operation |
| opClass | input | 4 | Operation class code |
| opReady | output | 1 | Sequencer can take an operation this cycle |
| stall | output | 1 | Execute holds a multi-iteration operation |
| valueReady | output | 1 | A result value becomes usable this cycle |
| flagsReady | output | 1 | Flag results become usable this cycle |
| exBusy | output | 1 | Execute stage occupied |
| memBusy | output | 1 | Memory stage occupied |
| wbBusy | output | 1 | Write stage occupied |

## Verification
The bench builds the block with its default widths: a 4-bit class code and a 3-bit iteration counter. All sixteen codes can therefore be driven, including the seven unused ones that must fall back to single-cycle ALU timing, and the counter reaches the five-iteration flag-setting long multiply. A back-to-back stream of random codes brings in the overlaps that the directed tests alone would miss. Examples are a one-cycle operation entering memory while a memory-ready multiply is in write, and a new code entering on the same edge that a long operation retires.

// File: rtl/mulSeqPkg.sv
package mulSeqPkg;

  localparam int CODE_W = 4;
  localparam int ITER_W = 3;

  typedef enum logic [CODE_W-1:0] {
    OP_ALU      = 4'd0,
    OP_ALU_SHK  = 4'd1,
    OP_ALU_SHR  = 4'd2,
    OP_HMUL     = 4'd3,
    OP_HMAC     = 4'd4,
    OP_MUL      = 4'd5,
    OP_MULF     = 4'd6,
    OP_LMUL     = 4'd7,
    OP_LMULF    = 4'd8
  } opClassE;

  // where in the pipe the value result appears
  typedef enum logic [1:0] {
    RDY_AFTER_EX  = 2'd0,
    RDY_AFTER_MEM = 2'd1,
    RDY_IN_EX     = 2'd2
  } rdyPointE;

  typedef struct packed {
    logic [ITER_W-1:0] iters;
    logic [ITER_W-1:0] valIter;
    rdyPointE          point;
    logic              setsFlags;
  } opProfileT;

  // control -> stages
  typedef struct packed {
    logic accept;
    logic exStep;
    logic exRetire;
  } seqCtrlT;

  // stages -> control
  typedef struct packed {
    logic              exValid;
    logic [ITER_W-1:0] exIter;
    opProfileT         exProf;
    logic              memValid;
    opProfileT         memProf;
    logic              wbValid;
    opProfileT         wbProf;
  } stageStatT;

  function automatic opProfileT mkProf(input int n, input int v,
                                       input rdyPointE p, input logic f);
    opProfileT r;
    r.iters     = ITER_W'(n);
    r.valIter   = ITER_W'(v);
    r.point     = p;
    r.setsFlags = f;
    return r;
  endfunction

  function automatic opProfileT profileOf(input logic [CODE_W-1:0] code);
    opProfileT r;
    case (opClassE'(code))
      OP_ALU_SHR: r = mkProf(2, 0, RDY_AFTER_EX,  1'b0);
      OP_HMUL:    r = mkProf(1, 0, RDY_AFTER_MEM, 1'b0);
      OP_HMAC:    r = mkProf(2, 0, RDY_AFTER_EX,  1'b0);
      OP_MUL:     r = mkProf(2, 0, RDY_AFTER_MEM, 1'b0);
      OP_MULF:    r = mkProf(4, 3, RDY_IN_EX,     1'b1);
      OP_LMUL:    r = mkProf(3, 0, RDY_AFTER_MEM, 1'b0);
      OP_LMULF:   r = mkProf(5, 4, RDY_IN_EX,     1'b1);
      default:    r = mkProf(1, 0, RDY_AFTER_EX,  1'b0);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mulSeqStages.sv
module mulSeqStages
  import mulSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrlT           ctrl,
  input  logic [CODE_W-1:0] inClass,
  output stageStatT         stat
);

  logic              exValid, memValid, wbValid;
  logic [ITER_W-1:0] exIter;
  opProfileT         exProf, memProf, wbProf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      exValid  <= 1'b0;
      exIter   <= '0;
      exProf   <= '0;
      memValid <= 1'b0;
      memProf  <= '0;
      wbValid  <= 1'b0;
      wbProf   <= '0;
    end else begin
      if (ctrl.accept) begin
        exValid <= 1'b1;
        exIter  <= ITER_W'(1);
        exProf  <= profileOf(inClass);
      end else if (ctrl.exRetire) begin
        exValid <= 1'b0;
      end else if (ctrl.exStep) begin
        exIter <= exIter + ITER_W'(1);
      end
      memValid <= ctrl.exRetire;
      if (ctrl.exRetire) memProf <= exProf;
      wbValid <= memValid;
      wbProf  <= memProf;
    end
  end

  always_comb begin
    stat.exValid  = exValid;
    stat.exIter   = exIter;
    stat.exProf   = exProf;
    stat.memValid = memValid;
    stat.memProf  = memProf;
    stat.wbValid  = wbValid;
    stat.wbProf   = wbProf;
  end

  // iteration counter stays inside the class's iteration window
  assert_iter_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    exValid |-> (exIter >= ITER_W'(1) && exIter <= exProf.iters));

  // an operation with iterations left stays put with the same profile
  assert_hold_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    (exValid && exIter != exProf.iters) |=> (exValid && $stable(exProf)));

  // memory is only entered from execute, write only from memory
  assert_mem_from_ex_R11: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> $past(exValid));
  assert_wb_from_mem_R11: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> $past(memValid));

endmodule

// File: rtl/mulSeqCtrl.sv
module mulSeqCtrl
  import mulSeqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      opValid,
  input  stageStatT stat,
  output seqCtrlT   ctrl,
  output logic      opReady,
  output logic      stall,
  output logic      valueReady,
  output logic      flagsReady
);

  logic exLast, exEarly, valFromEx, valFromMem, valFromWb;

  always_comb begin
    exLast  = stat.exValid && (stat.exIter == stat.exProf.iters);
    exEarly = stat.exValid && !exLast;

    stall   = exEarly;
    opReady = !exEarly;

    ctrl.accept   = opValid && !exEarly;
    ctrl.exStep   = exEarly;
    ctrl.exRetire = exLast;

    valFromEx  = stat.exValid && (stat.exProf.point == RDY_IN_EX) &&
                 (stat.exIter == stat.exProf.valIter + ITER_W'(1));
    valFromMem = stat.memValid && (stat.memProf.point == RDY_AFTER_EX);
    valFromWb  = stat.wbValid && (stat.wbProf.point == RDY_AFTER_MEM);

    valueReady = valFromEx || valFromMem || valFromWb;
    flagsReady = stat.memValid && stat.memProf.setsFlags;
  end

  // flags of a flag-setting multiply trail its value by exactly one cycle
  assert_flags_after_value_R9: assert property (@(posedge clk) disable iff (!rstN)
    flagsReady |-> $past(valueReady));

  // no acceptance is possible while the stall is raised
  assert_stall_blocks_R12: assert property (@(posedge clk) disable iff (!rstN)
    (stall && opValid) |=> stat.exIter != ITER_W'(1));

endmodule

// File: rtl/mulExecSeq.sv
module mulExecSeq
  import mulSeqPkg::*;
#(
  parameter int CLASS_W = mulSeqPkg::CODE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               opValid,
  input  logic [CLASS_W-1:0] opClass,
  output logic               opReady,
  output logic               stall,
  output logic               valueReady,
  output logic               flagsReady,
  output logic               exBusy,
  output logic               memBusy,
  output logic               wbBusy
);

  seqCtrlT   ctrl;
  stageStatT stat;

  mulSeqCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .opValid    (opValid),
    .stat       (stat),
    .ctrl       (ctrl),
    .opReady    (opReady),
    .stall      (stall),
    .valueReady (valueReady),
    .flagsReady (flagsReady)
  );

  mulSeqStages u_stages (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .inClass (CODE_W'(opClass)),
    .stat    (stat)
  );

  assign exBusy  = stat.exValid;
  assign memBusy = stat.memValid;
  assign wbBusy  = stat.wbValid;

endmodule

// File: tb/mulExecSeq_bench.sv
`timescale 1ns/1ps
module mulExecSeq_bench;

  localparam int MAXC = 4096;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opClass = 4'd0;
  logic opReady, stall, valueReady, flagsReady, exBusy, memBusy, wbBusy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  bit eEx[MAXC], eStall[MAXC], eMem[MAXC], eWb[MAXC], eVal[MAXC], eFlag[MAXC];

  always #2 clk = ~clk;

  mulExecSeq u_mulExecSeq (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opClass(opClass),
    .opReady(opReady), .stall(stall), .valueReady(valueReady),
    .flagsReady(flagsReady), .exBusy(exBusy), .memBusy(memBusy), .wbBusy(wbBusy)
  );

  // iterations per class (R3, R10)
  function automatic int bIters(input logic [3:0] c);
    case (c)
      4'd2, 4'd4, 4'd5: return 2;
      4'd6: return 4;
      4'd7: return 3;
      4'd8: return 5;
      default: return 1;
    endcase
  endfunction

  // edges after acceptance at which the value strobe interval starts
  function automatic int bValOff(input logic [3:0] c);
    int n;
    n = bIters(c);
    case (c)
      4'd3, 4'd5, 4'd7: return n + 1;
      4'd6: return 3;
      4'd8: return 4;
      default: return n;
    endcase
  endfunction

  task automatic schedule(input int e, input logic [3:0] c);
    int n;
    n = bIters(c);
    for (int k = 0; k < n; k++) eEx[e+k] = 1'b1;
    for (int k = 0; k < n - 1; k++) eStall[e+k] = 1'b1;
    eMem[e+n]   = 1'b1;
    eWb[e+n+1]  = 1'b1;
    eVal[e+bValOff(c)] = 1'b1;
    if (c == 4'd6 || c == 4'd8) eFlag[e+n] = 1'b1;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual %0b expected %0b", tag, cyc, act, exp);
    end
  endtask

  task automatic checkAll();
    chk("R3 R12 stall", stall, eStall[cyc]);
    chk("R2 opReady", opReady, !eStall[cyc]);
    chk("R4 R5 R6 R7 R8 R9 R10 valueReady", valueReady, eVal[cyc]);
    chk("R9 flagsReady", flagsReady, eFlag[cyc]);
    chk("R3 exBusy", exBusy, eEx[cyc]);
    chk("R11 memBusy", memBusy, eMem[cyc]);
    chk("R11 wbBusy", wbBusy, eWb[cyc]);
  endtask

  // one cycle: check at negedge, drive, pass the edge, update the model
  task automatic step(input logic v, input logic [3:0] c);
    bit acc;
    checkAll();
    acc = v && !eStall[cyc];
    opValid = v;
    opClass = c;
    @(posedge clk);
    #0.5;
    cyc++;
    if (acc) schedule(cyc, c);
    @(negedge clk);
  endtask

  task automatic runAll();
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs during reset
    chk("R1 reset opReady", opReady, 1'b1);
    chk("R1 reset stall", stall, 1'b0);
    chk("R1 reset valueReady", valueReady, 1'b0);
    chk("R1 reset flagsReady", flagsReady, 1'b0);
    chk("R1 reset exBusy", exBusy, 1'b0);
    chk("R1 reset memBusy", memBusy, 1'b0);
    chk("R1 reset wbBusy", wbBusy, 1'b0);
    rstN = 1'b1;
    // directed: every code alone, then held valid during stall (R12, R10)
    for (int c = 0; c < 16; c++) begin
      step(1'b1, 4'(c));
      step(1'b0, 4'd0);
      repeat (6) step(1'b0, 4'd0);
      step(1'b1, 4'(c));
      repeat (3) step(1'b1, 4'd15 - 4'(c));
      repeat (8) step(1'b0, 4'd0);
    end
    // back-to-back corners: long flag op followed by single-cycle ops
    step(1'b1, 4'd8);
    repeat (5) step(1'b1, 4'd0);
    step(1'b1, 4'd7);
    repeat (4) step(1'b1, 4'd1);
    repeat (8) step(1'b0, 4'd0);
    // constrained random stream
    for (int i = 0; i < 2500; i++) begin
      logic [3:0] c;
      c = ($urandom % 4 == 0) ? 4'(9 + $urandom % 7) : 4'($urandom % 9);
      step(($urandom % 4) != 0, c);
    end
    repeat (10) step(1'b0, 4'd0);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual hung expected finished");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule